// File: doc/BRIEF.md
# Split-Phase External SRAM Access Controller

This controller sits between a microcoded stack processor and an asynchronous external SRAM. Each memory access is split into a start operation and a later completion, so the processor can keep issuing unrelated micro-instructions while the SRAM is working. A read starts in the cycle the processor stores an address. A write needs two steps: the address is stored first, and storing the data then starts the access. A registered `busy` flag tells the processor's wait micro-instruction how long to stall.

Every access lasts a fixed number of clock cycles, set by the parameter `RAM_CNT`. The number of wait states is `RAM_CNT-1` when `RAM_CNT` is above 1 and zero otherwise, so `busy` is high for one cycle plus the wait states. Read data is captured from the SRAM bus in the final access cycle and held. A separate fetch command copies the held value into a registered output that feeds the top of stack.

All SRAM pins are driven from registers. Write data is split into an output bus, an input bus and a drive enable, which form the bidirectional data lines at the pad.

Top module: `sram_split_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are 1, `sram_drv` is 0 and `fetch_data` is 0.
- R2: If `cmd_rd_start` is sampled while idle, then from the next cycle `busy` is 1, `sram_ce_n` and `sram_oe_n` are 0 and `sram_addr` equals the sampled `cmd_addr`. `busy` is 1 exactly when `sram_ce_n` is 0.
- R3: An accepted access keeps `busy` at 1 for exactly 1+WS consecutive cycles, where WS = RAM_CNT-1 if RAM_CNT>1 and WS = 0 otherwise.
- R4: The read value on `sram_din` in the last busy cycle of a read is held until the next read completes. A `cmd_fetch` sampled at an edge loads the held value into `fetch_data`. Without `cmd_fetch`, `fetch_data` does not change.
- R5: `cmd_wr_addr` only stores `cmd_addr` as the write address and starts no access. A later `cmd_wr_data` starts a write of `cmd_wdata` to the most recently stored write address.
- R6: During a write, `sram_we_n` is 0, `sram_oe_n` is 1 and `sram_drv` is 1 for every busy cycle. During a read, `sram_we_n` is 1 and `sram_drv` is 0.
- R7: A `cmd_rd_start` or `cmd_wr_data` sampled while `busy` is 1 is ignored. `sram_addr`, `sram_dout` and the length of the running access are unchanged, and no access follows.
- R8: `cmd_wr_addr` and `cmd_fetch` are accepted while `busy` is 1. A fetch during a read in progress returns the value held before that read.
- R9: If `cmd_rd_start` and `cmd_wr_data` are sampled together while idle, the read is started and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_rd_start | input | 1 | Store address and start a read |
| cmd_wr_addr | input | 1 | Store the write address |
| cmd_wr_data | input | 1 | Store write data and start the write |
| cmd_fetch | input | 1 | Copy held read data to `fetch_data` |
| cmd_addr | input | ADDR_W | Address for read start or write address store |
| cmd_wdata | input | DATA_W | Write data |
| busy | output | 1 | Access in progress; the processor stalls its wait on this |
| fetch_data | output | DATA_W | Fetched read value for the top of stack |
| sram_addr | output | ADDR_W | SRAM address |
| sram_dout | output | DATA_W | Data driven toward the SRAM |
| sram_din | input | DATA_W | Data returned from the SRAM |
| sram_drv | output | 1 | Pad drive enable for `sram_dout` |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |

## Verification
The assertions assume the processor follows the command protocol. Starts during an access are allowed, and the checker confirms they are dropped. The assertions also assume `sram_din` is stable in the last cycle of a read. The bench's SRAM model is combinational from the registered address and enables, which keeps it within that assumption. Random traffic always drives start commands at negative edges, so they are sampled cleanly. Overlapping starts, a fetch during a read, and a read and write start in the same cycle are placed deliberately as directed cases.

// File: rtl/sram_split_pkg.sv
package sram_split_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_RD   = 2'd1,
    ACC_WR   = 2'd2
  } acc_kind_t;

  // wait states added beyond the first access cycle
  function automatic int wait_states(input int ram_cnt);
    return (ram_cnt > 1) ? ram_cnt - 1 : 0;
  endfunction

endpackage

// File: rtl/sram_split_seq.sv
module sram_split_seq
  import sram_split_pkg::*;
#(
  parameter int RAM_CNT = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      req_rd,
  input  logic      req_wr,
  output logic      launch_rd,
  output logic      launch_wr,
  output logic      last,
  output logic      busy,
  output acc_kind_t kind
);

  localparam int WS = wait_states(RAM_CNT);
  localparam int CW = $clog2(WS + 2);

  logic [CW-1:0] cnt;

  // read wins over a write start in the same cycle; nothing starts while busy
  assign launch_rd = req_rd & ~busy;
  assign launch_wr = req_wr & ~req_rd & ~busy;
  assign last      = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      kind <= ACC_IDLE;
    end else if (launch_rd || launch_wr) begin
      busy <= 1'b1;
      cnt  <= CW'(WS);
      kind <= launch_rd ? ACC_RD : ACC_WR;
    end else if (last) begin
      busy <= 1'b0;
      kind <= ACC_IDLE;
    end else if (busy) begin
      cnt <= cnt - CW'(1);
    end
  end

endmodule

// File: rtl/sram_split_pins.sv
module sram_split_pins #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wa_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              launch_rd,
  input  logic              launch_wr,
  input  logic              last,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dout,
  output logic              sram_drv,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n
);

  logic [ADDR_W-1:0] wa_q;
  logic [ADDR_W-1:0] wa_use;

  // a store in the same cycle as the data store is forwarded
  assign wa_use = wa_load ? addr_in : wa_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wa_q <= '0;
    end else if (wa_load) begin
      wa_q <= addr_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr <= '0;
      sram_dout <= '0;
      sram_drv  <= 1'b0;
      sram_ce_n <= 1'b1;
      sram_we_n <= 1'b1;
      sram_oe_n <= 1'b1;
    end else if (launch_rd) begin
      sram_addr <= addr_in;
      sram_ce_n <= 1'b0;
      sram_oe_n <= 1'b0;
      sram_we_n <= 1'b1;
      sram_drv  <= 1'b0;
    end else if (launch_wr) begin
      sram_addr <= wa_use;
      sram_dout <= wdata_in;
      sram_ce_n <= 1'b0;
      sram_oe_n <= 1'b1;
      sram_we_n <= 1'b0;
      sram_drv  <= 1'b1;
    end else if (last) begin
      sram_ce_n <= 1'b1;
      sram_oe_n <= 1'b1;
      sram_we_n <= 1'b1;
      sram_drv  <= 1'b0;
    end
  end

endmodule

// File: rtl/sram_split_rdhold.sv
module sram_split_rdhold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  input  logic              fetch,
  output logic [DATA_W-1:0] fetch_data
);

  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (capture) begin
      hold_q <= din;
    end
  end

  // a fetch at the capture edge still sees the previous value
  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_data <= '0;
    end else if (fetch) begin
      fetch_data <= hold_q;
    end
  end

endmodule

// File: rtl/sram_split_ctrl.sv
module sram_split_ctrl
  import sram_split_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 32,
  parameter int RAM_CNT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_rd_start,
  input  logic              cmd_wr_addr,
  input  logic              cmd_wr_data,
  input  logic              cmd_fetch,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic [DATA_W-1:0] fetch_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dout,
  input  logic [DATA_W-1:0] sram_din,
  output logic              sram_drv,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n
);

  logic      launch_rd;
  logic      launch_wr;
  logic      last;
  acc_kind_t kind;

  sram_split_seq #(.RAM_CNT(RAM_CNT)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_rd    (cmd_rd_start),
    .req_wr    (cmd_wr_data),
    .launch_rd (launch_rd),
    .launch_wr (launch_wr),
    .last      (last),
    .busy      (busy),
    .kind      (kind)
  );

  sram_split_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .wa_load   (cmd_wr_addr),
    .addr_in   (cmd_addr),
    .wdata_in  (cmd_wdata),
    .launch_rd (launch_rd),
    .launch_wr (launch_wr),
    .last      (last),
    .sram_addr (sram_addr),
    .sram_dout (sram_dout),
    .sram_drv  (sram_drv),
    .sram_ce_n (sram_ce_n),
    .sram_we_n (sram_we_n),
    .sram_oe_n (sram_oe_n)
  );

  sram_split_rdhold #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .capture    (last && (kind == ACC_RD)),
    .din        (sram_din),
    .fetch      (cmd_fetch),
    .fetch_data (fetch_data)
  );

endmodule

// File: rtl/sram_split_chk.sv
module sram_split_chk #(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 32,
  parameter int RAM_CNT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_rd_start,
  input logic              cmd_wr_data,
  input logic              cmd_fetch,
  input logic              busy,
  input logic [DATA_W-1:0] fetch_data,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [DATA_W-1:0] sram_dout,
  input logic              sram_drv,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n
);

  localparam int ACC_LEN = sram_split_pkg::wait_states(RAM_CNT) + 1;

  logic [15:0] run;

  always_ff @(posedge clk) begin
    if (rst)       run <= '0;
    else if (busy) run <= run + 16'd1;
    else           run <= '0;
  end

  assert_busy_len_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run == 16'(ACC_LEN)));

  assert_ce_follows_busy_R2: assert property (@(posedge clk) disable iff (rst)
    busy == !sram_ce_n);

  assert_busy_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_rd_start || cmd_wr_data));

  assert_write_pins_R6: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (sram_oe_n && sram_drv && !sram_ce_n));

  assert_read_pins_R6: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> (sram_we_n && !sram_drv));

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && (cmd_rd_start || cmd_wr_data)) |=> ($stable(sram_addr) && $stable(sram_dout)));

  assert_fetch_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !cmd_fetch |=> $stable(fetch_data));

endmodule

bind sram_split_ctrl sram_split_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_CNT(RAM_CNT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_rd_start (cmd_rd_start),
  .cmd_wr_data  (cmd_wr_data),
  .cmd_fetch    (cmd_fetch),
  .busy         (busy),
  .fetch_data   (fetch_data),
  .sram_addr    (sram_addr),
  .sram_dout    (sram_dout),
  .sram_drv     (sram_drv),
  .sram_ce_n    (sram_ce_n),
  .sram_we_n    (sram_we_n),
  .sram_oe_n    (sram_oe_n)
);

// File: tb/sram_split_ctrl_bench.sv
module sram_split_ctrl_bench;

  localparam int AW = 6;
  localparam int DW = 32;
  localparam int RC = 3;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_rd_start = 1'b0;
  logic          cmd_wr_addr = 1'b0;
  logic          cmd_wr_data = 1'b0;
  logic          cmd_fetch = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          busy;
  logic [DW-1:0] fetch_data;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_dout;
  logic [DW-1:0] sram_din;
  logic          sram_drv, sram_ce_n, sram_we_n, sram_oe_n;

  int total = 0;
  int bad   = 0;

  logic [DW-1:0] mem     [DEPTH];
  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] last_rd;

  always #5 clk = ~clk;

  sram_split_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RAM_CNT(RC)) u_sram_split_ctrl (
    .clk(clk), .rst(rst), .cmd_rd_start(cmd_rd_start), .cmd_wr_addr(cmd_wr_addr),
    .cmd_wr_data(cmd_wr_data), .cmd_fetch(cmd_fetch), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .busy(busy), .fetch_data(fetch_data),
    .sram_addr(sram_addr), .sram_dout(sram_dout), .sram_din(sram_din),
    .sram_drv(sram_drv), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n)
  );

  // asynchronous SRAM model
  assign sram_din = (!sram_ce_n && !sram_oe_n) ? mem[sram_addr] : '0;
  always @(posedge clk)
    if (!sram_ce_n && !sram_we_n && sram_drv) mem[sram_addr] <= sram_dout;

  function automatic int acc_len(input int rc);
    return (rc > 1) ? rc : 1;
  endfunction

  function automatic logic [DW-1:0] init_word(input int i);
    return (32'(i) * 32'h0101_0107) ^ 32'hA5C3_0F1E;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a negative edge
  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    chk(n == acc_len(RC), {tag, " R3 busy length"}, DW'(n), DW'(acc_len(RC)));
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    int n = 0;
    cmd_rd_start = 1'b1; cmd_addr = a;
    @(negedge clk);
    cmd_rd_start = 1'b0;
    chk(busy && !sram_ce_n && !sram_oe_n && sram_addr == a, "R2 read start",
        DW'({busy, sram_ce_n, sram_oe_n}), DW'(3'b100));
    while (busy) begin
      n++;
      chk(sram_we_n && !sram_drv, "R6 read pins", DW'({sram_we_n, sram_drv}), DW'(2'b10));
      @(negedge clk);
    end
    chk(n == acc_len(RC), "R3 read busy length", DW'(n), DW'(acc_len(RC)));
    last_rd = ref_mem[a];
  endtask

  task automatic do_fetch(input string tag, input logic [DW-1:0] exp);
    cmd_fetch = 1'b1;
    @(negedge clk);
    cmd_fetch = 1'b0;
    chk(fetch_data == exp, tag, fetch_data, exp);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n = 0;
    cmd_wr_addr = 1'b1; cmd_addr = a;
    @(negedge clk);
    cmd_wr_addr = 1'b0;
    chk(!busy && sram_ce_n, "R5 address store starts nothing", DW'(busy), '0);
    cmd_wr_data = 1'b1; cmd_wdata = d; cmd_addr = ~a;
    @(negedge clk);
    cmd_wr_data = 1'b0;
    while (busy) begin
      n++;
      chk(!sram_we_n && sram_oe_n && sram_drv, "R6 write pins",
          DW'({sram_we_n, sram_oe_n, sram_drv}), DW'(3'b011));
      chk(sram_addr == a && sram_dout == d, "R5 write address/data", sram_dout, d);
      @(negedge clk);
    end
    chk(n == acc_len(RC), "R3 write busy length", DW'(n), DW'(acc_len(RC)));
    ref_mem[a] = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = init_word(i);
      ref_mem[i] = init_word(i);
    end
    last_rd = '0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(!busy && sram_ce_n && sram_we_n && sram_oe_n && !sram_drv,
        "R1 reset pins", DW'({busy, sram_ce_n, sram_we_n, sram_oe_n, sram_drv}), DW'(5'b01110));
    chk(fetch_data == '0, "R1 reset fetch_data", fetch_data, '0);

    // basic read and fetch
    do_read(6'd5);
    do_fetch("R4 fetch after read", ref_mem[5]);
    // R4 hold: fetch again with no new read
    @(negedge clk);
    do_fetch("R4 held value refetch", ref_mem[5]);

    // write then read back
    do_write(6'd9, 32'hDEAD_BEEF);
    do_read(6'd9);
    do_fetch("R5 write readback", 32'hDEAD_BEEF);

    // R7 start while busy is ignored
    cmd_rd_start = 1'b1; cmd_addr = 6'd12;
    @(negedge clk);
    cmd_addr = 6'd40;   // second start during busy
    @(negedge clk);
    cmd_rd_start = 1'b0;
    chk(sram_addr == 6'd12, "R7 address unchanged", DW'(sram_addr), DW'(12));
    cmd_wr_data = 1'b1; cmd_wdata = 32'h1234_5678;
    @(negedge clk);
    cmd_wr_data = 1'b0;
    chk(sram_we_n && sram_dout != 32'h1234_5678, "R7 write start ignored", sram_dout, '0);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(!busy, "R7 no access follows", DW'(busy), '0);
    do_fetch("R7 read of first address", ref_mem[12]);
    last_rd = ref_mem[12];

    // R8 address store and fetch during a read in progress
    cmd_rd_start = 1'b1; cmd_addr = 6'd20;
    @(negedge clk);
    cmd_rd_start = 1'b0;
    cmd_wr_addr = 1'b1; cmd_addr = 6'd33; cmd_fetch = 1'b1;
    @(negedge clk);
    cmd_wr_addr = 1'b0; cmd_fetch = 1'b0;
    chk(fetch_data == ref_mem[12], "R8 fetch during read returns old value",
        fetch_data, ref_mem[12]);
    while (busy) @(negedge clk);
    cmd_wr_data = 1'b1; cmd_wdata = 32'hCAFE_0033;
    @(negedge clk);
    cmd_wr_data = 1'b0;
    chk(sram_addr == 6'd33 && !sram_we_n, "R8 write uses address stored while busy",
        DW'(sram_addr), DW'(33));
    wait_idle("R8");
    ref_mem[33] = 32'hCAFE_0033;
    do_fetch("R8 held value of overlapped read", ref_mem[20]);

    // R9 read and write start together: read wins
    cmd_wr_addr = 1'b1; cmd_addr = 6'd50;
    @(negedge clk);
    cmd_wr_addr = 1'b0;
    cmd_rd_start = 1'b1; cmd_wr_data = 1'b1; cmd_addr = 6'd51; cmd_wdata = 32'h0BAD_0BAD;
    @(negedge clk);
    cmd_rd_start = 1'b0; cmd_wr_data = 1'b0;
    chk(sram_we_n && !sram_oe_n && sram_addr == 6'd51, "R9 read wins",
        DW'({sram_we_n, sram_oe_n}), DW'(2'b10));
    wait_idle("R9");
    do_read(6'd50);
    do_fetch("R9 dropped write left memory", ref_mem[50]);

    // random traffic
    for (int k = 0; k < 300; k++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      if ($urandom % 2 == 0) begin
        do_write(a, $urandom);
      end else begin
        do_read(a);
        do_fetch("R4 random read data", ref_mem[a]);
      end
      repeat ($urandom % 3) @(negedge clk);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule